// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirection Unit

This block converts a group of wire-level interrupt inputs into posted message writes aimed at a processor. Each input line owns a redirection entry. The entry holds a disable bit, an input polarity, a trigger mode, an 8-bit vector and a destination identifier. When an enabled line becomes active, the unit places one message on a valid/ready output port. The message address is built from the entry's destination fields and the message data is the entry's vector.

Software reaches the block through a small memory-mapped slave port. The port decodes a select register, a data window and an end-of-interrupt register. Window reads and writes go to whichever internal index the select register holds. Each line's entry spans two consecutive internal indexes.

Level-triggered lines enter an in-service state once their message has been sent. They stay there until software writes that line's vector to the end-of-interrupt register. If the input is still active at that point, the line fires again without waiting for a new edge.

Top module: `irq_redirect_unit`

## Requirements
- R1: The slave port decodes offset 0x00 as the select register (8 bits, reads back in bits 7:0), 0x10 as the data window and 0x40 as the end-of-interrupt register. Any other offset reads as zero, and writes to it change nothing.
- R2: A window write to an entry word is visible to a window read on the next cycle. Low word: bit 16 disables the line, bit 15 selects level trigger, bit 13 selects active-low input, bits 7:0 hold the vector, and every other bit reads zero. High word: bits 31:24 hold the destination ID, bits 23:16 hold the extended ID, and bits 15:0 read zero.
- R3: Internal index 0x01 reads as version code VERSION_CODE in bits 7:0 and NUM_LINES-1 in bits 23:16. All other bits of that index read zero, and writes to it are ignored.
- R4: Line n's low word sits at internal index 0x10+2n and its high word at 0x11+2n. Indexes at or above 0x10+2*NUM_LINES, and unused indexes below 0x10, read zero.
- R5: After reset the select register is 0, every line is disabled (low word reads 0x00010000) and no message is pending.
- R6: An enabled level line whose input turns active produces one message with address {ID, extended ID, 16'h0} and data {24'h0, vector}. The message is valid on the third rising edge after the input change.
- R7: A level line that has sent a message sends no further message while in service. An end-of-interrupt write carrying a different vector does not release it.
- R8: An end-of-interrupt write carrying a level line's vector clears its in-service state. If the input is still active, a new message is valid on the rising edge after the one that takes the write.
- R9: An enabled edge line sends exactly one message per inactive-to-active transition, valid on the fourth rising edge after the input change. A held input does not send again.
- R10: With bit 13 set, a low input is active and a high input is inactive.
- R11: A disabled line never sends. An edge that arrives while the line is disabled is held, and its message is valid on the rising edge after the one that takes the enabling write.
- R12: When several lines are ready together, the lowest-numbered line is sent first and the others follow in index order.
- R13: A message stays valid with unchanged address and data until msg_ready is seen high. The valid output drops on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Raw interrupt lines |
| reg_wr | input | 1 | Slave write strobe |
| reg_addr | input | 8 | Slave byte offset |
| reg_wdata | input | 32 | Slave write data |
| reg_rdata | output | 32 | Slave read data, combinational from reg_addr |
| msg_valid | output | 1 | Message pending |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message payload |
| msg_ready | input | 1 | Message accepted |

## Verification
Each input stimulus has a fixed latency. A level input change shows a valid message after three rising edges: two synchronizer stages, then the message register. An edge input adds one more edge for the pending flop, giving four. Enabling a held line, or releasing an active level line with the end-of-interrupt write, yields a message one edge after the edge that takes the write. The bench drives every input on the falling edge and counts falling edges until msg_valid rises, then compares that count with these exact figures, so a message that is early or late fails just as a missing one does. Register reads are sampled 1 ns after the address is set on a falling edge, one full cycle after any write they are meant to observe.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    // slave port byte offsets
    localparam logic [7:0] OFS_SELECT = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;
    localparam logic [7:0] OFS_EOI    = 8'h40;

    // internal window indexes
    localparam logic [7:0] IDX_VERSION = 8'h01;
    localparam logic [7:0] IDX_TABLE   = 8'h10;

    // low-word bit positions
    localparam int LO_MASK_BIT  = 16;
    localparam int LO_LEVEL_BIT = 15;
    localparam int LO_POL_BIT   = 13;

    typedef struct packed {
        logic       mask;
        logic       level;
        logic       act_low;
        logic [7:0] vector;
        logic [7:0] dest_id;
        logic [7:0] dest_ext;
    } redir_entry_t;

endpackage

// File: rtl/irq_input_sync.sv
module irq_input_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_state_t;

    sync_state_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = raw_i;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.stage2;
endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in_i,
    input  logic mask_i,
    input  logic level_i,
    input  logic act_low_i,
    input  logic eoi_hit_i,
    input  logic grant_i,
    output logic ready_o
);
    typedef struct packed {
        logic prev_act;
        logic pend;
        logic insvc;
    } line_state_t;

    line_state_t line_d, line_q;
    logic active;
    logic rise;

    always_comb begin
        active          = sync_in_i ^ act_low_i;
        rise            = active && !line_q.prev_act;
        line_d          = line_q;
        line_d.prev_act = active;
        if (!level_i) begin
            line_d.insvc = 1'b0;
            if (grant_i) line_d.pend = 1'b0;
            if (rise)    line_d.pend = 1'b1;
        end else begin
            line_d.pend = 1'b0;
            if (eoi_hit_i) line_d.insvc = 1'b0;
            if (grant_i)   line_d.insvc = 1'b1;
        end
        ready_o = !mask_i && (level_i ? (active && !line_q.insvc) : line_q.pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    // R11
    masked_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> !mask_i);

    // R7
    insvc_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i && line_q.insvc) |-> !grant_i);

    // R9
    edge_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && !level_i) |-> line_q.pend);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req_i,
    input  logic             en_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    always_comb begin
        idx_o = '0;
        any_o = |req_i;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        grant_o = '0;
        if (en_i && any_o) grant_o[idx_o] = 1'b1;
    end
endmodule

// File: rtl/irq_redirect_unit.sv
module irq_redirect_unit
    import irq_redir_pkg::*;
#(
    parameter int         NUM_LINES    = 4,
    parameter logic [7:0] VERSION_CODE = 8'h21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 msg_valid,
    output logic [31:0]          msg_addr,
    output logic [31:0]          msg_data,
    input  logic                 msg_ready
);
    localparam int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int TABLE_END = 16 + 2 * NUM_LINES;

    typedef struct packed {
        logic [7:0]                   sel;
        redir_entry_t [NUM_LINES-1:0] tbl;
        logic                         msg_valid;
        logic [7:0]                   msg_id;
        logic [7:0]                   msg_ext;
        logic [7:0]                   msg_vec;
    } unit_state_t;

    unit_state_t unit_d, unit_q;

    logic [NUM_LINES-1:0] sync_lvl;
    logic [NUM_LINES-1:0] ready;
    logic [NUM_LINES-1:0] grant;
    logic [NUM_LINES-1:0] eoi_hit;
    logic [LINE_W-1:0]    win_idx;
    logic                 any_ready;
    logic [7:0]           tbl_off;
    logic [LINE_W-1:0]    line_sel;
    logic                 in_table;
    logic [31:0]          window_val;
    logic                 eoi_wr;
    logic                 unused_bits;

    assign unused_bits = ^{reg_wdata[14], reg_wdata[12:8], tbl_off[0], tbl_off[7:LINE_W+1]};

    irq_input_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (irq_in),
        .sync_o (sync_lvl)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irq_line_ctrl u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_in_i (sync_lvl[g]),
            .mask_i    (unit_q.tbl[g].mask),
            .level_i   (unit_q.tbl[g].level),
            .act_low_i (unit_q.tbl[g].act_low),
            .eoi_hit_i (eoi_hit[g]),
            .grant_i   (grant[g]),
            .ready_o   (ready[g])
        );
    end

    irq_prio_arb #(.N(NUM_LINES), .IDX_W(LINE_W)) u_arb (
        .req_i   (ready),
        .en_i    (!unit_q.msg_valid),
        .grant_o (grant),
        .idx_o   (win_idx),
        .any_o   (any_ready)
    );

    // window decode and read path
    always_comb begin
        tbl_off  = unit_q.sel - IDX_TABLE;
        line_sel = tbl_off[LINE_W:1];
        in_table = (unit_q.sel >= IDX_TABLE) && (int'(unit_q.sel) < TABLE_END);
        window_val = '0;
        if (unit_q.sel == IDX_VERSION) begin
            window_val = {8'h00, 8'(NUM_LINES - 1), 8'h00, VERSION_CODE};
        end else if (in_table) begin
            if (unit_q.sel[0]) begin
                window_val = {unit_q.tbl[line_sel].dest_id, unit_q.tbl[line_sel].dest_ext, 16'h0000};
            end else begin
                window_val[LO_MASK_BIT]  = unit_q.tbl[line_sel].mask;
                window_val[LO_LEVEL_BIT] = unit_q.tbl[line_sel].level;
                window_val[LO_POL_BIT]   = unit_q.tbl[line_sel].act_low;
                window_val[7:0]          = unit_q.tbl[line_sel].vector;
            end
        end
        case (reg_addr)
            OFS_SELECT: reg_rdata = {24'h0, unit_q.sel};
            OFS_WINDOW: reg_rdata = window_val;
            default:    reg_rdata = '0;
        endcase
    end

    // end-of-interrupt match
    always_comb begin
        eoi_wr = reg_wr && (reg_addr == OFS_EOI);
        for (int i = 0; i < NUM_LINES; i++) begin
            eoi_hit[i] = eoi_wr && unit_q.tbl[i].level
                         && (unit_q.tbl[i].vector == reg_wdata[7:0]);
        end
    end

    // next state
    always_comb begin
        unit_d = unit_q;
        if (reg_wr && reg_addr == OFS_SELECT) begin
            unit_d.sel = reg_wdata[7:0];
        end
        if (reg_wr && reg_addr == OFS_WINDOW && in_table) begin
            if (unit_q.sel[0]) begin
                unit_d.tbl[line_sel].dest_id  = reg_wdata[31:24];
                unit_d.tbl[line_sel].dest_ext = reg_wdata[23:16];
            end else begin
                unit_d.tbl[line_sel].mask    = reg_wdata[LO_MASK_BIT];
                unit_d.tbl[line_sel].level   = reg_wdata[LO_LEVEL_BIT];
                unit_d.tbl[line_sel].act_low = reg_wdata[LO_POL_BIT];
                unit_d.tbl[line_sel].vector  = reg_wdata[7:0];
            end
        end
        if (unit_q.msg_valid && msg_ready) begin
            unit_d.msg_valid = 1'b0;
        end
        if (!unit_q.msg_valid && any_ready) begin
            unit_d.msg_valid = 1'b1;
            unit_d.msg_id    = unit_q.tbl[win_idx].dest_id;
            unit_d.msg_ext   = unit_q.tbl[win_idx].dest_ext;
            unit_d.msg_vec   = unit_q.tbl[win_idx].vector;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) unit_q.tbl[i].mask <= 1'b1;
        end else begin
            unit_q <= unit_d;
        end
    end

    assign msg_valid = unit_q.msg_valid;
    assign msg_addr  = {unit_q.msg_id, unit_q.msg_ext, 16'h0000};
    assign msg_data  = {24'h0, unit_q.msg_vec};

    // R13
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R13
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);

    // R12
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R12
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> ((ready & (grant - 1'b1)) == '0));

    // R3
    version_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_WINDOW && unit_q.sel == IDX_VERSION)
        |-> (reg_rdata[23:16] == 8'(NUM_LINES - 1) && reg_rdata[7:0] == VERSION_CODE));
endmodule

// File: tb/test_irq_redirect_unit.sv
module test_irq_redirect_unit;
    localparam int         N   = 4;
    localparam logic [7:0] VER = 8'h21;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = 8'h00;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         msg_valid;
    logic [31:0]  msg_addr;
    logic [31:0]  msg_data;
    logic         msg_ready = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    irq_redirect_unit #(.NUM_LINES(N), .VERSION_CODE(VER)) i_irq_redirect_unit (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
        .msg_ready(msg_ready)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
        wr(8'h00, {24'h0, idx});
        wr(8'h10, d);
    endtask

    task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
        wr(8'h00, {24'h0, idx});
        rd(8'h10, d);
    endtask

    function automatic logic [31:0] lo_word(input bit m, input bit lvl, input bit alow, input logic [7:0] v);
        return {15'h0, m, lvl, 1'b0, alow, 5'h0, v};
    endfunction

    task automatic wait_msg(input int lim, output int cyc);
        cyc = 0;
        while (!msg_valid && cyc < lim) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ack();
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d);
        check(d == 32'h0, "R5 select after reset", d, 32'h0);
        win_rd(8'h10, d);
        check(d == 32'h0001_0000, "R5 line0 disabled after reset", d, 32'h0001_0000);
        win_rd(8'h16, d);
        check(d == 32'h0001_0000, "R5 line3 disabled after reset", d, 32'h0001_0000);
        check(msg_valid == 1'b0, "R5 no message after reset", {31'h0, msg_valid}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        logic [31:0] exp_ver;
        exp_ver = {8'h00, 8'(N - 1), 8'h00, VER};
        win_rd(8'h01, d);
        check(d == exp_ver, "R3 version read", d, exp_ver);
        win_wr(8'h01, 32'h0);
        win_rd(8'h01, d);
        check(d == exp_ver, "R3 version write ignored", d, exp_ver);
        win_wr(8'h17, 32'hA1B2_FFFF);
        win_rd(8'h17, d);
        check(d == 32'hA1B2_0000, "R2 R4 line3 high word readback", d, 32'hA1B2_0000);
        win_wr(8'h16, 32'hFFFF_FFFF);
        win_rd(8'h16, d);
        check(d == 32'h0001_A0FF, "R2 R4 line3 low word readback", d, 32'h0001_A0FF);
        win_wr(8'h16, 32'h0001_0000);
        win_rd(8'h17, d);
        check(d == 32'hA1B2_0000, "R4 low write leaves high word", d, 32'hA1B2_0000);
        win_wr(8'h18, 32'hFFFF_FFFF);
        win_rd(8'h18, d);
        check(d == 32'h0, "R4 index past table reads zero", d, 32'h0);
        win_rd(8'h05, d);
        check(d == 32'h0, "R4 unused low index reads zero", d, 32'h0);
        wr(8'h00, 32'h0000_0033);
        rd(8'h00, d);
        check(d == 32'h33, "R1 select readback", d, 32'h33);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, d);
        check(d == 32'h0, "R1 unmapped offset reads zero", d, 32'h0);
        rd(8'h00, d);
        check(d == 32'h33, "R1 unmapped write has no effect", d, 32'h33);
    endtask

    task automatic t_level();
        int c;
        win_wr(8'h11, 32'h5AC3_0000);
        win_wr(8'h10, lo_word(0, 1, 0, 8'h41));
        irq_in[0] = 1'b1;
        wait_msg(20, c);
        check(c == 3, "R6 level latency", c, 3);
        check(msg_addr == 32'h5AC3_0000, "R6 message address", msg_addr, 32'h5AC3_0000);
        check(msg_data == 32'h41, "R6 message data", msg_data, 32'h41);
        idle(3);
        check(msg_valid && msg_addr == 32'h5AC3_0000 && msg_data == 32'h41,
              "R13 held until ack", msg_data, 32'h41);
        ack();
        check(!msg_valid, "R13 valid drops after ack", {31'h0, msg_valid}, 32'h0);
        idle(5);
        check(!msg_valid, "R7 in service blocks resend", {31'h0, msg_valid}, 32'h0);
        wr(8'h40, 32'h99);
        idle(5);
        check(!msg_valid, "R7 wrong vector EOI ignored", {31'h0, msg_valid}, 32'h0);
        wr(8'h40, 32'h41);
        wait_msg(20, c);
        check(c == 1, "R8 EOI refire latency", c, 1);
        check(msg_data == 32'h41, "R8 refire data", msg_data, 32'h41);
        ack();
        irq_in[0] = 1'b0;
        idle(3);
        wr(8'h40, 32'h41);
        idle(5);
        check(!msg_valid, "R8 EOI on inactive line sends nothing", {31'h0, msg_valid}, 32'h0);
        win_wr(8'h10, lo_word(1, 0, 0, 8'h00));
    endtask

    task automatic t_edge();
        int c;
        win_wr(8'h13, 32'h1122_0000);
        win_wr(8'h12, lo_word(0, 0, 0, 8'h52));
        irq_in[1] = 1'b1;
        wait_msg(20, c);
        check(c == 4, "R9 edge latency", c, 4);
        check(msg_addr == 32'h1122_0000 && msg_data == 32'h52, "R9 edge message", msg_data, 32'h52);
        ack();
        idle(6);
        check(!msg_valid, "R9 held input no resend", {31'h0, msg_valid}, 32'h0);
        irq_in[1] = 1'b0;
        idle(4);
        irq_in[1] = 1'b1;
        wait_msg(20, c);
        check(c == 4 && msg_data == 32'h52, "R9 second edge message", c, 4);
        ack();
        irq_in[1] = 1'b0;
        idle(3);
    endtask

    task automatic t_polarity();
        int c;
        irq_in[2] = 1'b1;
        idle(3);
        win_wr(8'h14, lo_word(0, 1, 1, 8'h63));
        idle(5);
        check(!msg_valid, "R10 high input inactive when active-low", {31'h0, msg_valid}, 32'h0);
        irq_in[2] = 1'b0;
        wait_msg(20, c);
        check(c == 3 && msg_data == 32'h63, "R10 low input fires", msg_data, 32'h63);
        ack();
        irq_in[2] = 1'b1;
        idle(3);
        wr(8'h40, 32'h63);
        idle(3);
        win_wr(8'h14, lo_word(1, 0, 0, 8'h00));
        irq_in[2] = 1'b0;
        idle(3);
    endtask

    task automatic t_mask();
        int c;
        win_wr(8'h16, lo_word(1, 0, 0, 8'h74));
        irq_in[3] = 1'b1;
        idle(8);
        check(!msg_valid, "R11 disabled line silent", {31'h0, msg_valid}, 32'h0);
        wr(8'h10, lo_word(0, 0, 0, 8'h74));
        wait_msg(20, c);
        check(c == 1, "R11 held edge after enable latency", c, 1);
        check(msg_addr == 32'hA1B2_0000 && msg_data == 32'h74, "R11 held edge message", msg_data, 32'h74);
        ack();
        idle(4);
        check(!msg_valid, "R11 held edge sent once", {31'h0, msg_valid}, 32'h0);
        irq_in[3] = 1'b0;
        wr(8'h10, lo_word(1, 0, 0, 8'h74));
        idle(3);
    endtask

    task automatic t_priority();
        int c;
        win_wr(8'h12, lo_word(0, 1, 0, 8'h81));
        win_wr(8'h14, lo_word(0, 1, 0, 8'h82));
        irq_in[2:1] = 2'b11;
        wait_msg(20, c);
        check(c == 3 && msg_data == 32'h81, "R12 lowest line first", msg_data, 32'h81);
        ack();
        wait_msg(5, c);
        check(msg_valid && msg_data == 32'h82, "R12 next line follows", msg_data, 32'h82);
        ack();
        irq_in[2:1] = 2'b00;
        idle(3);
        wr(8'h40, 32'h81);
        wr(8'h40, 32'h82);
        idle(4);
        check(!msg_valid, "R12 nothing left after both served", {31'h0, msg_valid}, 32'h0);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_regs();
        t_level();
        t_edge();
        t_polarity();
        t_mask();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule